// File: doc/BRIEF.md
# Transactional Read/Write-Set Tracking Cache

This block is a small direct-mapped cache for a core that runs hardware transactions with deferred write-back. Each line holds one word. While a transaction is open, every access records the line it touches: a load sets a per-line read flag, and a store sets a per-line write flag. A store keeps its new value inside the line. Main memory does not see that value until the transaction commits. Outside a transaction, stores write through to memory in the same cycle and the flags are not touched.

Incoming coherence probes are checked against the flags. An aborting event wipes out every buffered value and clears all flags in one cycle. Three events abort the transaction:
- a probe that conflicts with a flagged line,
- an access that would displace a flagged line,
- an explicit abort command.

The abort pulse tells the core to branch to its fallback path, and a two-bit code gives the cause. A commit drains the written lines to memory, one per cycle. During that drain, accesses and probes are held off, so the transaction's writes appear to other agents all at the same moment. A one-cycle done pulse then closes the transaction.

Top module: `txc_cache`

## Requirements
- R1: After reset, no transaction is open. `busy`, `aborted`, `commit_done`, `rsp_valid` and `abort_cause` are all zero, and every line is invalid, so the first load of any address returns the memory word.
- R2: Inside a transaction, a store keeps its data in the line and drives no memory write. A later load of that address returns the buffered data. A load answers with `rsp_valid` and `rsp_data` in the cycle after it is accepted.
- R3: Outside a transaction, a store drives a memory write of its address and data in the same cycle. Loads and stores outside a transaction set no flags, so an invalidating probe to such a line after `tx_begin` causes no abort.
- R4: Inside a transaction, an invalidating probe (`snoop_inv`=1) that hits a valid line with its read or write flag set aborts with cause code 2'b01.
- R5: A non-invalidating probe (`snoop_inv`=0) that hits a line with its write flag set aborts with code 2'b01. The same probe on a line that has only its read flag set has no effect.
- R6: Inside a transaction, an access whose set holds a flagged line with a different tag aborts with code 2'b10. That access is dropped and gives no response.
- R7: `tx_abort` inside a transaction aborts with code 2'b11. Outside a transaction, `tx_abort` and `tx_end` are ignored, and `tx_begin` inside a transaction is ignored.
- R8: An abort pulses `aborted` for one cycle and closes the transaction at the same time. Lines with the write flag are invalidated, memory keeps its old values, and all flags are cleared.
- R9: `tx_end` raises `busy` from the next cycle. In each busy cycle the lowest-numbered written line is written to memory. When none are left, `commit_done` pulses for one cycle together with `tx_active` and `busy` falling.
- R10: While `busy` is high, a probe raises `snoop_stall` and is not evaluated, and accesses are not accepted.
- R11: When several abort causes occur in the same cycle, the reported code is chosen by priority: probe conflict first, then displacement, then explicit abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Open a transaction |
| tx_end | input | 1 | Request commit |
| tx_abort | input | 1 | Explicit abort |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Access word address; low bits select the set |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Load response data |
| snoop_valid | input | 1 | Incoming coherence probe |
| snoop_inv | input | 1 | 1 = invalidating probe, 0 = read probe |
| snoop_addr | input | ADDR_W | Probe address |
| snoop_stall | output | 1 | Probe refused during commit drain |
| tx_active | output | 1 | Transaction open (includes the drain) |
| busy | output | 1 | Commit drain in progress |
| aborted | output | 1 | One-cycle abort pulse (redirect to fallback) |
| abort_cause | output | 2 | Last abort cause: 01 conflict, 10 displacement, 11 explicit |
| commit_done | output | 1 | One-cycle commit completion pulse |
| mem_rd_addr | output | ADDR_W | Memory read address (combinational) |
| mem_rd_data | input | DATA_W | Memory read data, same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
The properties assume that memory answers a read in the same cycle it is asked. They also assume that a probe and an access do not target the same set in the same cycle unless the priority case is what is being tested, and that `tx_end` is not raised while the drain is running. The stimulus follows these rules:
- inputs are driven one nanosecond after a clock edge and held for exactly one cycle;
- the drain loop only issues probes and loads that are meant to be refused;
- multi-cause cycles are built deliberately, so that each priority pairing is seen once.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_CONFLICT = 2'b01,
        CAUSE_EVICT    = 2'b10,
        CAUSE_EXPLICIT = 2'b11
    } abort_cause_e;

    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_FLUSH = 1'b1
    } phase_e;

    // Fixed priority among simultaneous abort sources.
    function automatic abort_cause_e pick_cause(input logic conflict,
                                                input logic evict,
                                                input logic expl);
        if (conflict)  return CAUSE_CONFLICT;
        else if (evict) return CAUSE_EVICT;
        else if (expl)  return CAUSE_EXPLICIT;
        else            return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/txc_snoop_check.sv
module txc_snoop_check #(
    parameter int SETS  = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             en,
    input  logic             inv,
    input  logic             tx_on,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic [SETS-1:0]  vld,
    input  logic [SETS-1:0]  rd,
    input  logic [SETS-1:0]  wr,
    input  logic [TAG_W-1:0] tags [SETS],
    output logic             hit,
    output logic             conflict
);
    logic flagged;

    always_comb begin
        hit      = en && vld[idx] && (tags[idx] == tag);
        flagged  = inv ? (rd[idx] | wr[idx]) : wr[idx];
        conflict = hit && tx_on && flagged;
    end
endmodule

// File: rtl/txc_first_set.sv
module txc_first_set #(
    parameter int SETS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [SETS-1:0]  vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = SETS - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txc_cache.sv
module txc_cache
    import txc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_begin,
    input  logic              tx_end,
    input  logic              tx_abort,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              snoop_valid,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_stall,
    output logic              tx_active,
    output logic              busy,
    output logic              aborted,
    output logic [1:0]        abort_cause,
    output logic              commit_done,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    // Line state: valid, tag, data, and the transactional read/write flags.
    logic [SETS-1:0]   vld_q, rd_q, wr_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    phase_e            ph_q;
    logic              act_q;
    abort_cause_e      cause_q;
    logic              aborted_q, done_q, rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    logic              flushing;
    logic [IDX_W-1:0]  a_idx, s_idx, fl_idx;
    logic [TAG_W-1:0]  a_tag, s_tag;
    logic              acc_ok, a_hit, evict_hit, expl, abort_now;
    logic              do_acc, commit_go, begin_go, snp_en;
    logic              snp_hit, snp_conflict, fl_any;

    assign flushing = (ph_q == PH_FLUSH);
    assign a_idx    = req_addr[IDX_W-1:0];
    assign a_tag    = req_addr[ADDR_W-1:IDX_W];
    assign s_idx    = snoop_addr[IDX_W-1:0];
    assign s_tag    = snoop_addr[ADDR_W-1:IDX_W];
    assign snp_en   = snoop_valid && !flushing;

    txc_snoop_check #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
        .en       (snp_en),
        .inv      (snoop_inv),
        .tx_on    (act_q),
        .idx      (s_idx),
        .tag      (s_tag),
        .vld      (vld_q),
        .rd       (rd_q),
        .wr       (wr_q),
        .tags     (tag_q),
        .hit      (snp_hit),
        .conflict (snp_conflict)
    );

    txc_first_set #(.SETS(SETS), .IDX_W(IDX_W)) u_pick (
        .vec (wr_q),
        .any (fl_any),
        .idx (fl_idx)
    );

    always_comb begin
        acc_ok    = req_valid && !flushing;
        a_hit     = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
        evict_hit = acc_ok && act_q && !a_hit && (rd_q[a_idx] | wr_q[a_idx]);
        expl      = tx_abort && act_q && !flushing;
        abort_now = snp_conflict || evict_hit || expl;
        do_acc    = acc_ok && !abort_now;
        commit_go = tx_end && act_q && !flushing && !abort_now;
        begin_go  = tx_begin && !act_q;
    end

    // Memory side: drain writes during commit, write-through outside a transaction.
    assign mem_rd_addr = req_addr;
    assign mem_wr_en   = flushing ? fl_any : (do_acc && req_write && !act_q);
    assign mem_wr_addr = flushing ? {tag_q[fl_idx], fl_idx} : req_addr;
    assign mem_wr_data = flushing ? dat_q[fl_idx] : req_wdata;
    assign snoop_stall = snoop_valid && flushing;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            rd_q      <= '0;
            wr_q      <= '0;
            ph_q      <= PH_RUN;
            act_q     <= 1'b0;
            cause_q   <= CAUSE_NONE;
            aborted_q <= 1'b0;
            done_q    <= 1'b0;
            rsp_v_q   <= 1'b0;
            rsp_d_q   <= '0;
        end else begin
            aborted_q <= 1'b0;
            done_q    <= 1'b0;
            rsp_v_q   <= do_acc && !req_write;

            if (do_acc) begin
                vld_q[a_idx] <= 1'b1;
                tag_q[a_idx] <= a_tag;
                if (req_write) begin
                    dat_q[a_idx] <= req_wdata;
                    if (act_q) wr_q[a_idx] <= 1'b1;
                end else begin
                    if (!a_hit) dat_q[a_idx] <= mem_rd_data;
                    rsp_d_q <= a_hit ? dat_q[a_idx] : mem_rd_data;
                    if (act_q) rd_q[a_idx] <= 1'b1;
                end
            end

            if (begin_go) begin
                act_q   <= 1'b1;
                cause_q <= CAUSE_NONE;
            end

            if (abort_now) begin
                act_q     <= 1'b0;
                aborted_q <= 1'b1;
                cause_q   <= pick_cause(snp_conflict, evict_hit, expl);
                vld_q     <= vld_q & ~wr_q;
                rd_q      <= '0;
                wr_q      <= '0;
            end

            if (commit_go) ph_q <= PH_FLUSH;

            if (flushing) begin
                if (fl_any) begin
                    wr_q[fl_idx] <= 1'b0;
                end else begin
                    rd_q   <= '0;
                    act_q  <= 1'b0;
                    done_q <= 1'b1;
                    ph_q   <= PH_RUN;
                end
            end

            if (snp_hit && snoop_inv) vld_q[s_idx] <= 1'b0;
        end
    end

    assign rsp_valid   = rsp_v_q;
    assign rsp_data    = rsp_d_q;
    assign tx_active   = act_q;
    assign busy        = flushing;
    assign aborted     = aborted_q;
    assign abort_cause = cause_q;
    assign commit_done = done_q;

endmodule

// File: rtl/txc_checker.sv
module txc_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_end,
    input logic       busy,
    input logic       tx_active,
    input logic       aborted,
    input logic [1:0] abort_cause,
    input logic       commit_done,
    input logic       rsp_valid,
    input logic       mem_wr_en
);
    AST_ABORT_CODE: assert property (@(posedge clk) disable iff (rst)
        aborted |-> abort_cause != 2'b00);                          // R7
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        aborted |=> !aborted);                                      // R8
    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        aborted |-> (!tx_active && !busy));                         // R8
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !busy) |-> !mem_wr_en);                       // R2
    AST_DRAIN_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_end));                             // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit_done |=> !commit_done);                              // R9
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        commit_done |-> (!tx_active && !busy));                     // R9
    AST_QUIET_DRAIN: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rsp_valid);                                       // R10
endmodule

bind txc_cache txc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_end      (tx_end),
    .busy        (busy),
    .tx_active   (tx_active),
    .aborted     (aborted),
    .abort_cause (abort_cause),
    .commit_done (commit_done),
    .rsp_valid   (rsp_valid),
    .mem_wr_en   (mem_wr_en)
);

// File: tb/tb_txc_cache.sv
module tb_txc_cache;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_begin = 0, tx_end = 0, tx_abort = 0;
    logic       req_valid = 0, req_write = 0;
    logic [7:0] req_addr = 0, req_wdata = 0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       snoop_valid = 0, snoop_inv = 0;
    logic [7:0] snoop_addr = 0;
    logic       snoop_stall, tx_active, busy, aborted, commit_done;
    logic [1:0] abort_cause;
    logic [7:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [7:0] mem_rd_data;
    logic       mem_wr_en;

    logic [7:0] mem [256];
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    txc_cache dut (
        .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_end(tx_end), .tx_abort(tx_abort),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .snoop_valid(snoop_valid), .snoop_inv(snoop_inv), .snoop_addr(snoop_addr),
        .snoop_stall(snoop_stall), .tx_active(tx_active), .busy(busy), .aborted(aborted),
        .abort_cause(abort_cause), .commit_done(commit_done),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7) + 3);
    endfunction

    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 256; a++) mem[a] <= init_val(a);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        cyc();
        req_valid = 0; req_write = 0;
    endtask

    task automatic probe(input bit inv, input logic [7:0] a);
        snoop_valid = 1; snoop_inv = inv; snoop_addr = a;
        cyc();
        snoop_valid = 0; snoop_inv = 0;
    endtask

    task automatic cmd(input int which);
        tx_begin = (which == 0); tx_end = (which == 1); tx_abort = (which == 2);
        cyc();
        tx_begin = 0; tx_end = 0; tx_abort = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] dv [4];
        logic [7:0] old [4];
        logic [7:0] a, o;
        int nw;

        repeat (3) @(posedge clk);
        #1 rst = 0;
        cyc();
        // R1: reset state
        chk(tx_active == 0, "R1 tx_active", int'(tx_active), 0);
        chk(busy == 0, "R1 busy", int'(busy), 0);
        chk(aborted == 0, "R1 aborted", int'(aborted), 0);
        chk(commit_done == 0, "R1 commit_done", int'(commit_done), 0);
        chk(abort_cause == 0, "R1 abort_cause", int'(abort_cause), 0);
        chk(rsp_valid == 0, "R1 rsp_valid", int'(rsp_valid), 0);
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 4; s++) begin
                a = 8'(t * 36 + s * 1 + (t * 4));
                access(0, a, 0);
                chk(rsp_valid == 1, "R1 load valid", int'(rsp_valid), 1);
                chk(rsp_data == init_val(int'(a)), "R1 cold load", int'(rsp_data), int'(init_val(int'(a))));
            end
        end

        // R3: write-through outside a transaction, no flags
        for (int s = 0; s < 4; s++) begin
            a = 8'(8'h40 + s);
            access(1, a, 8'(8'hA0 + s));
            chk(mem[a] == 8'(8'hA0 + s), "R3 write-through", int'(mem[a]), 8'hA0 + s);
            access(0, a, 0);
            chk(rsp_data == 8'(8'hA0 + s), "R3 load back", int'(rsp_data), 8'hA0 + s);
        end
        cmd(0);
        chk(tx_active == 1, "R3 begin", int'(tx_active), 1);
        probe(1, 8'h40);
        chk(aborted == 0, "R3 untracked probe", int'(aborted), 0);
        chk(tx_active == 1, "R3 still open", int'(tx_active), 1);
        cmd(2);
        chk(aborted == 1 && abort_cause == 2'b11, "R7 explicit", int'(abort_cause), 3);
        chk(tx_active == 0, "R8 closed", int'(tx_active), 0);

        // R2 / R9 / R10: commit sweep over 0..4 written lines
        for (int n = 0; n <= 4; n++) begin
            int t = 8 + n;
            for (int s = 0; s < 4; s++) begin
                old[s] = mem[8'(t * 4 + s)];
                dv[s] = 8'((n * 16 + s) ^ 8'h33);
            end
            cmd(0);
            for (int s = 0; s < n; s++) access(1, 8'(t * 4 + s), dv[s]);
            for (int s = 0; s < n; s++) begin
                access(0, 8'(t * 4 + s), 0);
                chk(rsp_data == dv[s], "R2 buffered load", int'(rsp_data), int'(dv[s]));
                chk(mem[8'(t * 4 + s)] == old[s], "R2 memory untouched", int'(mem[8'(t * 4 + s)]), int'(old[s]));
            end
            cmd(1);
            chk(busy == 1, "R9 busy after end", int'(busy), 1);
            nw = 0;
            for (int k = 0; k < 12; k++) begin
                if (!busy) break;
                snoop_valid = 1; snoop_inv = 1; snoop_addr = 8'(t * 4);
                req_valid = 1; req_write = 0; req_addr = 8'(t * 4);
                #1;
                chk(snoop_stall == 1, "R10 stall", int'(snoop_stall), 1);
                if (mem_wr_en) begin
                    chk(mem_wr_addr == 8'(t * 4 + nw), "R9 drain order", int'(mem_wr_addr), t * 4 + nw);
                    chk(mem_wr_data == dv[nw], "R9 drain data", int'(mem_wr_data), int'(dv[nw]));
                    nw++;
                end
                cyc();
                chk(rsp_valid == 0, "R10 no access", int'(rsp_valid), 0);
                snoop_valid = 0; snoop_inv = 0; req_valid = 0;
            end
            chk(commit_done == 1, "R9 done pulse", int'(commit_done), 1);
            chk(tx_active == 0, "R9 closed", int'(tx_active), 0);
            chk(nw == n, "R9 write count", nw, n);
            chk(aborted == 0, "R10 probe ignored", int'(aborted), 0);
            for (int s = 0; s < 4; s++) begin
                o = (s < n) ? dv[s] : old[s];
                chk(mem[8'(t * 4 + s)] == o, "R9 memory", int'(mem[8'(t * 4 + s)]), int'(o));
            end
        end

        // Abort paths per set
        for (int s = 0; s < 4; s++) begin
            a = 8'(80 + s);
            o = mem[a];
            cmd(0);
            access(1, a, 8'hEE);
            probe(1, a);
            chk(aborted == 1 && abort_cause == 2'b01, "R4 inv on written", int'(abort_cause), 1);
            chk(tx_active == 0, "R8 closed", int'(tx_active), 0);
            chk(mem[a] == o, "R8 memory kept", int'(mem[a]), int'(o));
            access(0, a, 0);
            chk(rsp_data == o, "R8 discarded", int'(rsp_data), int'(o));

            cmd(0);
            access(0, a, 0);
            probe(0, a);
            chk(aborted == 0, "R5 read probe on read line", int'(aborted), 0);
            probe(1, a);
            chk(aborted == 1 && abort_cause == 2'b01, "R4 inv on read line", int'(abort_cause), 1);

            cmd(0);
            access(1, a, 8'h5C);
            probe(0, a);
            chk(aborted == 1 && abort_cause == 2'b01, "R5 read probe on written", int'(abort_cause), 1);
            access(0, a, 0);
            chk(rsp_data == o, "R8 discarded after read probe", int'(rsp_data), int'(o));

            cmd(0);
            access(0, a, 0);
            access(0, 8'(120 + s), 0);
            chk(aborted == 1 && abort_cause == 2'b10, "R6 displacement", int'(abort_cause), 2);
            chk(rsp_valid == 0, "R6 dropped", int'(rsp_valid), 0);
            cmd(0);
            probe(1, a);
            chk(aborted == 0, "R8 flags cleared", int'(aborted), 0);
            cmd(2);

            cmd(2);
            chk(aborted == 0, "R7 abort outside", int'(aborted), 0);
            cmd(1);
            chk(busy == 0 && commit_done == 0, "R7 end outside", int'(busy), 0);
            cmd(0);
            cmd(0);
            chk(tx_active == 1 && aborted == 0, "R7 nested begin", int'(tx_active), 1);
            cmd(2);
            chk(aborted == 1 && abort_cause == 2'b11, "R7 explicit", int'(abort_cause), 3);
        end

        // R11: priority among simultaneous causes
        cmd(0);
        access(0, 8'h90, 0);
        access(0, 8'h91, 0);
        snoop_valid = 1; snoop_inv = 1; snoop_addr = 8'h90;
        req_valid = 1; req_addr = 8'hA1; tx_abort = 1;
        cyc();
        snoop_valid = 0; snoop_inv = 0; req_valid = 0; tx_abort = 0;
        chk(aborted == 1 && abort_cause == 2'b01, "R11 conflict first", int'(abort_cause), 1);
        cmd(0);
        access(0, 8'h91, 0);
        req_valid = 1; req_addr = 8'hA1; tx_abort = 1;
        cyc();
        req_valid = 0; tx_abort = 0;
        chk(aborted == 1 && abort_cause == 2'b10, "R11 displacement over explicit", int'(abort_cause), 2);
        chk(rsp_valid == 0, "R11 access dropped", int'(rsp_valid), 0);

        cyc();
        summary();
    end
endmodule